// File: doc/BRIEF.md
# Two-Wide Register Rename Map with Free List

This block turns the logical register numbers of two instructions per cycle into physical register numbers. Every instruction that writes a register receives a physical register taken from a pool of free ones. Each source operand is translated to the physical register that was most recently handed out for that logical register, in program order. A later writer therefore never waits on an earlier reader or writer of the same logical register, because it gets its own storage. For every writer the block also reports the physical register that the destination was mapped to before. The commit logic returns that register once no one can still read it.

The pair arrives on a valid/ready handshake. `in_ready` is high when the pool holds at least as many free registers as the pair has writers. A pair is accepted in a cycle where `in_valid` and `in_ready` are both high. The renamed results are driven combinationally in that same cycle, and `out_valid` marks them. Downstream logic cannot push back on the results. It throttles the block by holding `in_valid` low. While `in_valid` is high, the producer keeps the pair stable until it is accepted. `stall` flags a pair that is offered but refused. Freed registers come back on up to `NUM_REL` release ports per cycle. These ports have no handshake: a release is always taken.

Top module: `rn_rename`

## Requirements
- R1: After reset, logical register i maps to physical register i, and physical registers NUM_LOG to NUM_PHYS-1 (16 of them by default) are free.
- R2: In an accepted pair, each source operand is translated through the map as it stood before the pair, unless R4 applies.
- R3: Each accepted lane with both its lane-valid and write flags set gets a free physical register. The lowest-numbered free register goes to the first writer in lane order, and the next lowest goes to the second writer. The two registers of a pair never coincide.
- R4: When lane 0 writes a logical register that a lane 1 source names, that lane 1 source returns lane 0's new physical register.
- R5: When both lanes write the same logical register, the map keeps lane 1's register, and lane 1's previous mapping reports lane 0's new register.
- R6: For every writing lane, the block reports the physical register its destination was mapped to just before that lane.
- R7: `in_ready` is high exactly when the free count is at least the number of writing lanes in the offered pair. A refused pair raises `stall` (in_valid high, in_ready low) and changes neither the map nor the free pool. No pair is ever split.
- R8: A register returned on a release port can be allocated from the next cycle on, and not in the same cycle.
- R9: With `in_valid` low, or with a lane's valid flag low, the map and the free pool do not change for that pair or lane, and `out_valid` stays low while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A pair is offered |
| in_ready | output | 1 | Enough free registers for the offered pair |
| stall | output | 1 | Pair offered but refused |
| i0_vld | input | 1 | Lane 0 holds an instruction |
| i0_wr | input | 1 | Lane 0 writes a register |
| i0_dst | input | LW | Lane 0 logical destination |
| i0_src_a | input | LW | Lane 0 logical source A |
| i0_src_b | input | LW | Lane 0 logical source B |
| i1_vld | input | 1 | Lane 1 holds an instruction |
| i1_wr | input | 1 | Lane 1 writes a register |
| i1_dst | input | LW | Lane 1 logical destination |
| i1_src_a | input | LW | Lane 1 logical source A |
| i1_src_b | input | LW | Lane 1 logical source B |
| out_valid | output | 1 | Pair accepted this cycle; results valid |
| o0_pdst | output | PW | Lane 0 new physical destination (0 if not writing) |
| o0_psrc_a | output | PW | Lane 0 physical source A |
| o0_psrc_b | output | PW | Lane 0 physical source B |
| o0_pold | output | PW | Lane 0 previous mapping of destination (0 if not writing) |
| o1_pdst | output | PW | Lane 1 new physical destination (0 if not writing) |
| o1_psrc_a | output | PW | Lane 1 physical source A |
| o1_psrc_b | output | PW | Lane 1 physical source B |
| o1_pold | output | PW | Lane 1 previous mapping of destination (0 if not writing) |
| rel_vld | input | NUM_REL | Per-port release strobe |
| rel_preg | input | NUM_REL*PW | Released physical registers, port k at bits [k*PW +: PW] |

## Verification
The handshake outputs, the stall flag and all renamed results depend on the current state by combinational logic only. They are due in the same cycle as the offered pair, so the bench drives inputs on the falling edge and samples shortly after. A map update or an allocation becomes visible after one rising edge, and so does a release. The bench checks these effects in the next cycle's results, including the cycle of a release, when the returned register must not yet count. A reference model in the bench advances on each rising edge, using the same acceptance rule that is checked.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int unsigned RN_NUM_LOG  = 16;
  localparam int unsigned RN_NUM_PHYS = 32;
  localparam int unsigned RN_NUM_REL  = 2;
  localparam int unsigned RN_LANES    = 2;
endpackage

// File: rtl/rn_pick.sv
module rn_pick #(
  parameter int N = 32,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int NUM_LOG  = 16,
  parameter int NUM_PHYS = 32,
  parameter int NUM_REL  = 2,
  parameter int LANES    = 2,
  localparam int PW = $clog2(NUM_PHYS),
  localparam int CW = $clog2(NUM_PHYS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANES-1:0]      alloc_vld,
  input  logic [LANES*PW-1:0]   alloc_idx,
  input  logic [NUM_REL-1:0]    rel_vld,
  input  logic [NUM_REL*PW-1:0] rel_preg,
  output logic [PW-1:0]         pick0,
  output logic [PW-1:0]         pick1,
  output logic [CW-1:0]         free_cnt
);
  logic [NUM_PHYS-1:0] free_q, free_d, clr_mask, set_mask, vec1;
  logic                found0, found1;
  logic [CW-1:0]       n_alloc, n_rel;

  rn_pick #(.N(NUM_PHYS)) u_pick0 (.vec(free_q), .found(found0), .idx(pick0));

  always_comb begin
    vec1 = free_q;
    vec1[pick0] = 1'b0;
  end

  rn_pick #(.N(NUM_PHYS)) u_pick1 (.vec(vec1), .found(found1), .idx(pick1));

  always_comb begin
    free_cnt = '0;
    for (int i = 0; i < NUM_PHYS; i++) free_cnt = free_cnt + CW'(free_q[i]);
  end

  always_comb begin
    clr_mask = '0;
    n_alloc  = '0;
    for (int l = 0; l < LANES; l++) begin
      if (alloc_vld[l]) begin
        clr_mask[alloc_idx[l*PW +: PW]] = 1'b1;
        n_alloc = n_alloc + 1'b1;
      end
    end
    set_mask = '0;
    n_rel    = '0;
    for (int k = 0; k < NUM_REL; k++) begin
      if (rel_vld[k]) begin
        set_mask[rel_preg[k*PW +: PW]] = 1'b1;
        n_rel = n_rel + 1'b1;
      end
    end
    free_d = (free_q & ~clr_mask) | set_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PHYS; i++) free_q[i] <= (i >= NUM_LOG);
    end else begin
      free_q <= free_d;
    end
  end

  // R3
  alloc_from_pool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_vld[0] |-> (found0 && free_q[alloc_idx[0 +: PW]]));

  // R3
  alloc_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_vld[1] |-> (found0 && free_q[alloc_idx[PW +: PW]]));

  // R3
  distinct_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&alloc_vld) |-> (found1 && alloc_idx[0 +: PW] != alloc_idx[PW +: PW]));

  // R8
  pool_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (int'(free_cnt) == int'($past(free_cnt)) - int'($past(n_alloc)) + int'($past(n_rel))));

  genvar gk;
  generate
    for (gk = 0; gk < NUM_REL; gk++) begin : g_rel
      // R8
      release_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_vld[gk] |-> !free_q[rel_preg[gk*PW +: PW]]);
      // R8
      release_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_vld[gk] |=> free_q[$past(rel_preg[gk*PW +: PW])]);
    end
  endgenerate
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int NUM_LOG  = 16,
  parameter int NUM_PHYS = 32,
  parameter int NRD      = 6,
  localparam int LW = $clog2(NUM_LOG),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NRD*LW-1:0] rd_addr,
  output logic [NRD*PW-1:0] rd_data,
  input  logic              we0,
  input  logic [LW-1:0]     wa0,
  input  logic [PW-1:0]     wd0,
  input  logic              we1,
  input  logic [LW-1:0]     wa1,
  input  logic [PW-1:0]     wd1
);
  logic [PW-1:0] map_q [NUM_LOG];

  genvar gr;
  generate
    for (gr = 0; gr < NRD; gr++) begin : g_rd
      assign rd_data[gr*PW +: PW] = map_q[rd_addr[gr*LW +: LW]];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LOG; i++) map_q[i] <= PW'(i);
    end else begin
      if (we0) map_q[wa0] <= wd0;
      if (we1) map_q[wa1] <= wd1;
    end
  end

  // R5
  later_lane_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we1 |=> (map_q[$past(wa1)] == $past(wd1)));

  // R3
  lane0_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we0 && !(we1 && wa1 == wa0)) |=> (map_q[$past(wa0)] == $past(wd0)));
endmodule

// File: rtl/rn_rename.sv
module rn_rename
  import rn_pkg::*;
#(
  parameter int NUM_LOG  = RN_NUM_LOG,
  parameter int NUM_PHYS = RN_NUM_PHYS,
  parameter int NUM_REL  = RN_NUM_REL,
  localparam int LW = $clog2(NUM_LOG),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  output logic                  stall,
  input  logic                  i0_vld,
  input  logic                  i0_wr,
  input  logic [LW-1:0]         i0_dst,
  input  logic [LW-1:0]         i0_src_a,
  input  logic [LW-1:0]         i0_src_b,
  input  logic                  i1_vld,
  input  logic                  i1_wr,
  input  logic [LW-1:0]         i1_dst,
  input  logic [LW-1:0]         i1_src_a,
  input  logic [LW-1:0]         i1_src_b,
  output logic                  out_valid,
  output logic [PW-1:0]         o0_pdst,
  output logic [PW-1:0]         o0_psrc_a,
  output logic [PW-1:0]         o0_psrc_b,
  output logic [PW-1:0]         o0_pold,
  output logic [PW-1:0]         o1_pdst,
  output logic [PW-1:0]         o1_psrc_a,
  output logic [PW-1:0]         o1_psrc_b,
  output logic [PW-1:0]         o1_pold,
  input  logic [NUM_REL-1:0]    rel_vld,
  input  logic [NUM_REL*PW-1:0] rel_preg
);
  localparam int LANES = RN_LANES;
  localparam int NRD   = 3 * LANES;
  localparam int CW    = $clog2(NUM_PHYS + 1);

  logic          w0, w1, fire, we0, we1;
  logic [1:0]    need;
  logic [CW-1:0] fl_cnt;
  logic [PW-1:0] pick0, pick1, pd0, pd1;
  logic [NRD*LW-1:0] rd_addr;
  logic [NRD*PW-1:0] rd_data;
  logic [LW-1:0]     l1_src [2];
  logic [PW-1:0]     l1_psrc [2];

  assign w0   = i0_vld & i0_wr;
  assign w1   = i1_vld & i1_wr;
  assign need = {1'b0, w0} + {1'b0, w1};

  assign in_ready  = (fl_cnt >= CW'(need));
  assign stall     = in_valid & ~in_ready;
  assign fire      = in_valid & in_ready;
  assign out_valid = fire;
  assign we0       = fire & w0;
  assign we1       = fire & w1;

  assign pd0 = pick0;
  assign pd1 = w0 ? pick1 : pick0;

  rn_free_list #(
    .NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS), .NUM_REL(NUM_REL), .LANES(LANES)
  ) u_free (
    .clk(clk), .rst_n(rst_n),
    .alloc_vld({we1, we0}),
    .alloc_idx({pd1, pd0}),
    .rel_vld(rel_vld), .rel_preg(rel_preg),
    .pick0(pick0), .pick1(pick1), .free_cnt(fl_cnt)
  );

  assign rd_addr = {i1_dst, i1_src_b, i1_src_a, i0_dst, i0_src_b, i0_src_a};

  rn_map_table #(
    .NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS), .NRD(NRD)
  ) u_map (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .we0(we0), .wa0(i0_dst), .wd0(pd0),
    .we1(we1), .wa1(i1_dst), .wd1(pd1)
  );

  assign o0_psrc_a = rd_data[0*PW +: PW];
  assign o0_psrc_b = rd_data[1*PW +: PW];
  assign o0_pold   = w0 ? rd_data[2*PW +: PW] : '0;
  assign o0_pdst   = w0 ? pd0 : '0;

  assign l1_src[0] = i1_src_a;
  assign l1_src[1] = i1_src_b;

  genvar gs;
  generate
    for (gs = 0; gs < 2; gs++) begin : g_l1src
      assign l1_psrc[gs] = (w0 && l1_src[gs] == i0_dst) ? pd0 : rd_data[(3+gs)*PW +: PW];
    end
  endgenerate

  assign o1_psrc_a = l1_psrc[0];
  assign o1_psrc_b = l1_psrc[1];
  assign o1_pold   = !w1 ? '0 : (w0 && i1_dst == i0_dst) ? pd0 : rd_data[5*PW +: PW];
  assign o1_pdst   = w1 ? pd1 : '0;

  // R7
  refused_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (fl_cnt >= $past(fl_cnt)));

  // R9
  idle_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (fl_cnt >= $past(fl_cnt)));

  // R4
  bypass_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && w0 && i1_src_a == i0_dst) |-> (o1_psrc_a == o0_pdst));

  // R3
  pair_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && w0 && w1) |-> (o0_pdst != o1_pdst));

  // R5
  same_dst_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && w0 && w1 && i0_dst == i1_dst) |-> (o1_pold == o0_pdst));
endmodule

// File: tb/rn_rename_tb_top.sv
`timescale 1ns/1ps
module rn_rename_tb_top;
  localparam int NL = 16;
  localparam int NP = 32;
  localparam int LW = 4;
  localparam int PW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic in_valid, in_ready, stall, out_valid;
  logic i0_vld, i0_wr, i1_vld, i1_wr;
  logic [LW-1:0] i0_dst, i0_src_a, i0_src_b, i1_dst, i1_src_a, i1_src_b;
  logic [PW-1:0] o0_pdst, o0_psrc_a, o0_psrc_b, o0_pold;
  logic [PW-1:0] o1_pdst, o1_psrc_a, o1_psrc_b, o1_pold;
  logic [1:0]    rel_vld;
  logic [2*PW-1:0] rel_preg;

  rn_rename dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .stall(stall),
    .i0_vld(i0_vld), .i0_wr(i0_wr), .i0_dst(i0_dst), .i0_src_a(i0_src_a), .i0_src_b(i0_src_b),
    .i1_vld(i1_vld), .i1_wr(i1_wr), .i1_dst(i1_dst), .i1_src_a(i1_src_a), .i1_src_b(i1_src_b),
    .out_valid(out_valid),
    .o0_pdst(o0_pdst), .o0_psrc_a(o0_psrc_a), .o0_psrc_b(o0_psrc_b), .o0_pold(o0_pold),
    .o1_pdst(o1_pdst), .o1_psrc_a(o1_psrc_a), .o1_psrc_b(o1_psrc_b), .o1_pold(o1_pold),
    .rel_vld(rel_vld), .rel_preg(rel_preg)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int map_m [NL];
  bit [NP-1:0] free_m, pend_m;

  task automatic chk(string req, string what, int got, int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int lowest(bit [NP-1:0] v);
    for (int i = 0; i < NP; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic step(bit iv, bit v0, bit w0, int d0, int a0, int b0,
                      bit v1, bit w1, int d1, int a1, int b1, bit do_rel, string ctx);
    int ew0, ew1, need, cnt, p0, p1, pd0, pd1, ea0, eb0, eo0, ea1, eb1, eo1, st;
    bit ready, fire;
    bit [NP-1:0] rel_bits;
    @(negedge clk);
    in_valid = iv;
    i0_vld = v0; i0_wr = w0; i0_dst = LW'(d0); i0_src_a = LW'(a0); i0_src_b = LW'(b0);
    i1_vld = v1; i1_wr = w1; i1_dst = LW'(d1); i1_src_a = LW'(a1); i1_src_b = LW'(b1);
    rel_vld = '0; rel_preg = '0; rel_bits = '0;
    if (do_rel) begin
      st = $urandom_range(NP - 1);
      for (int k = 0; k < NP; k++) begin
        int r;
        r = (st + k) % NP;
        if (pend_m[r] && !rel_bits[r]) begin
          if (!rel_vld[0]) begin rel_vld[0] = 1'b1; rel_preg[0 +: PW] = PW'(r); rel_bits[r] = 1'b1; end
          else if (!rel_vld[1]) begin rel_vld[1] = 1'b1; rel_preg[PW +: PW] = PW'(r); rel_bits[r] = 1'b1; end
        end
      end
    end
    #1;
    ew0 = int'(v0 & w0); ew1 = int'(v1 & w1);
    need = ew0 + ew1; cnt = $countones(free_m);
    ready = (cnt >= need); fire = iv & ready;
    p0 = lowest(free_m);
    p1 = lowest(free_m & ~(NP'(1) << p0));
    pd0 = p0; pd1 = ew0 ? p1 : p0;
    ea0 = map_m[a0]; eb0 = map_m[b0]; eo0 = map_m[d0];
    ea1 = (ew0 && a1 == d0) ? pd0 : map_m[a1];
    eb1 = (ew0 && b1 == d0) ? pd0 : map_m[b1];
    eo1 = (ew0 && d1 == d0) ? pd0 : map_m[d1];
    chk("R7", {ctx, " in_ready"}, int'(in_ready), int'(ready));
    chk("R7", {ctx, " stall"}, int'(stall), int'(iv & ~ready));
    chk("R9", {ctx, " out_valid"}, int'(out_valid), int'(fire));
    if (fire) begin
      if (v0) begin
        chk("R2", {ctx, " l0 src a"}, int'(o0_psrc_a), ea0);
        chk("R2", {ctx, " l0 src b"}, int'(o0_psrc_b), eb0);
      end
      if (ew0) begin
        chk("R3", {ctx, " l0 pdst"}, int'(o0_pdst), pd0);
        chk("R6", {ctx, " l0 old"}, int'(o0_pold), eo0);
      end
      if (v1) begin
        chk((ew0 && a1 == d0) ? "R4" : "R2", {ctx, " l1 src a"}, int'(o1_psrc_a), ea1);
        chk((ew0 && b1 == d0) ? "R4" : "R2", {ctx, " l1 src b"}, int'(o1_psrc_b), eb1);
      end
      if (ew1) begin
        chk("R3", {ctx, " l1 pdst"}, int'(o1_pdst), pd1);
        chk((ew0 && d1 == d0) ? "R5" : "R6", {ctx, " l1 old"}, int'(o1_pold), eo1);
      end
    end
    @(posedge clk);
    if (fire && ew0) begin pend_m[eo0] = 1'b1; map_m[d0] = pd0; free_m[pd0] = 1'b0; end
    if (fire && ew1) begin pend_m[eo1] = 1'b1; map_m[d1] = pd1; free_m[pd1] = 1'b0; end
    free_m = free_m | rel_bits;
    pend_m = pend_m & ~rel_bits;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    in_valid = 0; i0_vld = 0; i0_wr = 0; i0_dst = 0; i0_src_a = 0; i0_src_b = 0;
    i1_vld = 0; i1_wr = 0; i1_dst = 0; i1_src_a = 0; i1_src_b = 0;
    rel_vld = 0; rel_preg = 0;
    for (int i = 0; i < NL; i++) map_m[i] = i;
    for (int i = 0; i < NP; i++) free_m[i] = (i >= NL);
    pend_m = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1: identity map and 16 free registers seen through reads and handshake
    for (int i = 0; i < NL / 4; i++)
      step(1, 1, 0, 0, 4*i, 4*i+1, 1, 0, 0, 4*i+2, 4*i+3, 0, "R1 reset map");
    step(1, 1, 1, 0, 0, 0, 1, 1, 1, 1, 1, 0, "R1 first alloc");

    // R4: lane 1 reads lane 0 destination
    step(1, 1, 1, 3, 2, 2, 1, 1, 7, 3, 3, 0, "R4 bypass");
    // R5: both lanes write the same register, then read it back
    step(1, 1, 1, 5, 5, 5, 1, 1, 5, 5, 0, 0, "R5 same dst");
    step(1, 1, 0, 0, 5, 3, 1, 0, 0, 7, 5, 0, "R5 readback");
    // R9: idle pair and invalid lanes leave state alone
    step(0, 1, 1, 9, 9, 9, 1, 1, 9, 9, 9, 0, "R9 idle");
    step(1, 0, 1, 9, 9, 9, 0, 1, 9, 9, 9, 0, "R9 empty lanes");
    step(1, 1, 0, 0, 9, 9, 1, 0, 0, 9, 9, 0, "R9 readback");

    // R7: drain the pool without releases until refused
    while ($countones(free_m) > 0)
      step(1, 1, 1, $urandom_range(15), 1, 2, 0, 0, 0, 0, 0, 0, "R7 drain");
    step(1, 1, 1, 4, 4, 4, 0, 0, 0, 0, 0, 0, "R7 refused");
    step(1, 1, 0, 0, 4, 3, 1, 0, 0, 5, 7, 0, "R7 no change");
    // R8: release while empty: not usable now, usable next cycle
    step(1, 1, 1, 6, 6, 6, 0, 0, 0, 0, 0, 1, "R8 release cycle");
    step(1, 1, 1, 6, 6, 6, 0, 0, 0, 0, 0, 0, "R8 next cycle");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      step(($urandom_range(9) != 0), $urandom_range(7) != 0, $urandom_range(3) != 0,
           $urandom_range(15), $urandom_range(15), $urandom_range(15),
           $urandom_range(7) != 0, $urandom_range(3) != 0,
           $urandom_range(15), $urandom_range(15), $urandom_range(15),
           $urandom_range(2) != 0, "rand");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule